// File: doc/BRIEF.md
# Byte-Program Flash Command Interface

This block models the device side of a byte-wide flash part. Writes on a parallel bus carry command codes. A program opcode arms the interface, and the next bus write supplies the target address and the byte to store. A write state machine then runs for a parameterised number of clock cycles. It merges the byte into a small internal cell file and afterwards records the outcome in sticky error bits of a status byte. A read returns either a cell or the status byte, depending on the current read mode.

The programming-voltage supply is modelled as a single input flag. Cells start erased (all ones). Programming can only clear bits, so a program that asks for a one where the cell already holds a zero does not complete as requested. The bus is a plain strobe interface: one `cmd_we` pulse is one write, and the block never applies back-pressure. A write that arrives during programming is dropped; it is not held. Read data is a snapshot taken when the read enable rises, and it holds until the next rise.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset every cell reads 0xFF, the read mode is array, and the status byte reads 0x80.
- R2: A write of 0x40 or 0x10 arms a program and switches reads to status. The next write is taken as data and address whatever its value, and it starts the program.
- R3: Status bit 7 reads 0 for the PROG_CYCLES cycles that a program runs and 1 at all other times.
- R4: A completed program leaves the addressed cell equal to its old value ANDed with the written data.
- R5: When the cell after a program differs from the written data, status bits 4 and 5 are set.
- R6: If `vpp_ok` is low on the data write, the program is aborted. Status bits 3 and 4 are set, the cell is unchanged and bit 7 stays 1.
- R7: A write of 0xFF, when not armed, selects read-array mode.
- R8: A write of CLR_OP (default 0x50) clears status bits 3, 4 and 5 and leaves bit 7 unchanged.
- R9: Status bits 3, 4 and 5 stay set through later successful programs until a clear command.
- R10: `rd_data` changes only on a cycle in which `rd_en` has just risen. It then shows the status byte in status mode, or the cell at `cmd_addr` in array mode.
- R11: Bus writes made while a program runs have no effect.
- R12: A write of 0x70, when not armed, selects read-status mode. The status byte holds bit 7 ready, bit 5 data-write fail, bit 4 program fail and bit 3 low voltage; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | One-cycle bus write strobe |
| cmd_addr | input | AW | Cell address for writes and array reads |
| cmd_data | input | 8 | Command code or program data |
| vpp_ok | input | 1 | Programming voltage present |
| rd_en | input | 1 | Read enable; a rising level takes a snapshot |
| rd_data | output | 8 | Latched read data |

## Verification
The assertions assume that `cmd_we` is a clean one-cycle pulse per command. They also assume that `rd_en` returns low between reads, so that each read produces exactly one rising edge. The bench drives every input at the falling clock edge and holds `rd_en` high for a single cycle per read. It gives a program its full PROG_CYCLES plus a margin before it reads the outcome. Random stimulus chooses the opcode, address, data and voltage state, and it keeps `vpp_ok` stable around each data write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OP_PROG_A     = 8'h40;
  localparam logic [7:0] OP_PROG_B     = 8'h10;
  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_STAT  = 8'h70;
  localparam logic [7:0] OP_CLEAR_DEF  = 8'h50;

  typedef enum logic { MODE_ARRAY = 1'b0, MODE_STATUS = 1'b1 } rd_mode_e;

  typedef struct packed {
    logic arm;
    logic start;
    logic to_array;
    logic to_status;
    logic clear;
  } cmd_ev_t;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter logic [7:0] CLR_OP = OP_CLEAR_DEF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  logic [7:0] data,
  input  logic     busy,
  output cmd_ev_t  ev,
  output rd_mode_e mode
);
  logic armed_q;

  always_comb begin
    ev = '0;
    if (we && !busy) begin
      if (armed_q)                                   ev.start     = 1'b1;
      else if (data == OP_PROG_A || data == OP_PROG_B) ev.arm     = 1'b1;
      else if (data == OP_READ_ARRAY)                ev.to_array  = 1'b1;
      else if (data == CLR_OP)                       ev.clear     = 1'b1;
      else if (data == OP_READ_STAT)                 ev.to_status = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode    <= MODE_ARRAY;
    end else begin
      if (ev.arm)        armed_q <= 1'b1;
      else if (ev.start) armed_q <= 1'b0;
      if (ev.arm || ev.to_status || ev.start) mode <= MODE_STATUS;
      else if (ev.to_array)                   mode <= MODE_ARRAY;
    end
  end

  // R11
  armed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !armed_q);

  // R2
  arm_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.arm |=> (armed_q && mode == MODE_STATUS));
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm #(
  parameter int AW          = 4,
  parameter int PROG_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          vpp_ok,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  output logic          busy,
  output logic          abort_vpp,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign busy      = busy_q;
  assign abort_vpp = start && !vpp_ok;
  assign wr_en     = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (start && vpp_ok) begin
      busy_q  <= 1'b1;
      cnt_q   <= LAST;
      wr_addr <= addr;
      wr_data <= data;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == '0));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_q,
  output logic [7:0]    wr_old
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cell_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cell_q[i] <= 8'hFF;
      else if (wr_en && wr_addr == AW'(i))
        cell_q[i] <= cell_q[i] & wr_data;
    end
  end

  assign rd_q   = cell_q[rd_addr];
  assign wr_old = cell_q[wr_addr];

  // R4
  only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cell_q[$past(wr_addr)] & ~$past(wr_old)) == 8'h00));
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       abort_vpp,
  input  logic       verify_fail,
  input  logic       clear,
  input  logic       rd_en,
  input  rd_mode_e   mode,
  input  logic [7:0] array_q,
  output logic [7:0] rd_data
);
  logic       e3_q, e4_q, e5_q, rd_en_q;
  logic [7:0] stat;
  logic       snap;

  assign stat = {~busy, 1'b0, e5_q, e4_q, e3_q, 3'b000};
  assign snap = rd_en && !rd_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e3_q <= 1'b0;
      e4_q <= 1'b0;
      e5_q <= 1'b0;
    end else if (clear) begin
      e3_q <= 1'b0;
      e4_q <= 1'b0;
      e5_q <= 1'b0;
    end else begin
      if (abort_vpp)               e3_q <= 1'b1;
      if (abort_vpp || verify_fail) e4_q <= 1'b1;
      if (verify_fail)             e5_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      rd_en_q <= rd_en;
      if (snap) rd_data <= (mode == MODE_STATUS) ? stat : array_q;
    end
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((e3_q || e4_q || e5_q) && !clear) |=> (e3_q || e4_q || e5_q));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!e3_q && !e4_q && !e5_q));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(rd_data));
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int         AW          = 4,
  parameter int         PROG_CYCLES = 8,
  parameter logic [7:0] CLR_OP      = OP_CLEAR_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic          vpp_ok,
  input  logic          rd_en,
  output logic [7:0]    rd_data
);
  cmd_ev_t       ev;
  rd_mode_e      mode;
  logic          busy, abort_vpp, wr_en, verify_fail;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data, array_q, wr_old;

  flash_cmd_decode #(.CLR_OP(CLR_OP)) u_dec (
    .clk(clk), .rst_n(rst_n), .we(cmd_we), .data(cmd_data),
    .busy(busy), .ev(ev), .mode(mode)
  );

  flash_wsm #(.AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_wsm (
    .clk(clk), .rst_n(rst_n), .start(ev.start), .vpp_ok(vpp_ok),
    .addr(cmd_addr), .data(cmd_data), .busy(busy), .abort_vpp(abort_vpp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_cell_array #(.AW(AW)) u_cells (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(cmd_addr), .rd_q(array_q), .wr_old(wr_old)
  );

  assign verify_fail = wr_en && ((wr_old & wr_data) != wr_data);

  flash_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .busy(busy), .abort_vpp(abort_vpp),
    .verify_fail(verify_fail), .clear(ev.clear), .rd_en(rd_en),
    .mode(mode), .array_q(array_q), .rd_data(rd_data)
  );

  // R6
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_vpp |=> !busy);
endmodule

// File: tb/flash_cmd_if_test.sv
module flash_cmd_if_test;
  localparam int AW = 4;
  localparam int PC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = '0;
  logic          vpp_ok = 1'b1;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_data;

  int tests = 0, fails = 0;
  logic [7:0] ref_mem [16];
  logic e3 = 0, e4 = 0, e5 = 0;

  always #5 clk = ~clk;

  flash_cmd_if #(.AW(AW), .PROG_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .vpp_ok(vpp_ok), .rd_en(rd_en), .rd_data(rd_data)
  );

  function automatic logic [7:0] stat_exp(input logic bsy);
    return {~bsy, 1'b0, e5, e4, e3, 3'b000};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); cmd_we = 1'b1; cmd_addr = a; cmd_data = d;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; cmd_addr = a;
    @(negedge clk); v = rd_data; rd_en = 1'b0;
  endtask

  task automatic model_prog(input logic [AW-1:0] a, input logic [7:0] d);
    logic [7:0] nv;
    nv = ref_mem[a] & d;
    if (nv != d) begin e4 = 1; e5 = 1; end
    ref_mem[a] = nv;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d,
                      input logic [7:0] op, input logic vpp);
    vpp_ok = vpp;
    wr('0, op);
    wr(a, d);
    vpp_ok = 1'b1;
    if (!vpp) begin e3 = 1; e4 = 1; end
    else begin
      repeat (PC + 1) @(negedge clk);
      model_prog(a, d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, hold;
    int seed;
    for (int i = 0; i < 16; i++) ref_mem[i] = 8'hFF;
    seed = $urandom(32'd24681);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: array mode after reset, erased cells, idle status
    rd(4'd3, v);  check("R1 cell", v, 8'hFF);
    wr('0, 8'h70);
    rd('0, v);    check("R1/R12 status", v, 8'h80);

    // R2, R4: plain program of an erased cell
    prog(4'd2, 8'hA5, 8'h40, 1'b1);
    rd('0, v);    check("R2 auto status", v, stat_exp(0));
    wr('0, 8'hFF);
    rd(4'd2, v);  check("R4/R7 cell", v, ref_mem[2]);

    // R3, R11: busy status and ignored writes while busy
    wr('0, 8'h10);
    wr(4'd5, 8'h0F);
    rd('0, v);    check("R3 busy", v, stat_exp(1));
    wr('0, 8'hFF);
    wr('0, 8'h50);
    repeat (PC) @(negedge clk);
    model_prog(4'd5, 8'h0F);
    rd(4'd5, v);  check("R11 mode kept", v, stat_exp(0));
    wr('0, 8'hFF);
    rd(4'd5, v);  check("R4 cell 5", v, 8'h0F);

    // R2: data byte equal to an opcode is still data
    wr('0, 8'h70);
    prog(4'd7, 8'hFF, 8'h40, 1'b1);
    wr('0, 8'hFF);
    rd(4'd7, v);  check("R2 data FF", v, 8'hFF);

    // R5: program a 1 into a cleared bit
    prog(4'd5, 8'hF0, 8'h40, 1'b1);
    rd('0, v);    check("R5 fail bits", v, stat_exp(0));
    check("R5 bit5", v & 8'h20, 8'h20);

    // R9: errors survive a clean program
    prog(4'd9, 8'h3C, 8'h10, 1'b1);
    rd('0, v);    check("R9 sticky", v, stat_exp(0));

    // R8: clear
    wr('0, 8'h50); e3 = 0; e4 = 0; e5 = 0;
    wr('0, 8'h70);
    rd('0, v);    check("R8 clear", v, 8'h80);

    // R6: low voltage abort
    prog(4'd11, 8'h00, 8'h40, 1'b0);
    rd('0, v);    check("R6 status", v, 8'h98);
    wr('0, 8'hFF);
    rd(4'd11, v); check("R6 cell unchanged", v, ref_mem[11]);

    // R10: snapshot holds while rd_en stays high
    wr('0, 8'h70);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); hold = rd_data;
    check("R10 snap", hold, stat_exp(0));
    wr('0, 8'hFF);
    repeat (2) @(negedge clk);
    check("R10 hold", rd_data, hold);
    rd_en = 1'b0;
    rd(4'd2, v);  check("R10 new edge", v, ref_mem[2]);

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [AW-1:0] a;
      logic [7:0] d, op;
      logic vp;
      a  = AW'($urandom % 16);
      d  = 8'($urandom);
      op = ($urandom % 2) ? 8'h40 : 8'h10;
      vp = ($urandom % 6) != 0;
      prog(a, d, op, vp);
      rd('0, v);  check(vp ? "R5/R9 rand status" : "R6 rand status", v, stat_exp(0));
      wr('0, 8'hFF);
      rd(a, v);   check("R4 rand cell", v, ref_mem[a]);
      if ($urandom % 4 == 0) begin
        wr('0, 8'h50); e3 = 0; e4 = 0; e5 = 0;
        wr('0, 8'h70);
        rd('0, v); check("R8 rand clear", v, 8'h80);
        wr('0, 8'hFF);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule